// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder, 64 Bits

This block adds two 64-bit operands and a carry-in in pure combinational logic. No carry ripples from one slice to the next. Each bit forms a generate and a propagate term. Groups of four bits reduce those terms to one group pair. Four groups form a 16-bit section through one lookahead carry unit, and four sections meet at a second-level lookahead carry unit.

The same lookahead carry unit serves every level. Each instance turns four propagate/generate pairs and a carry-in into four carries, each written as a flat sum of products. Each instance also reports its own combined propagate/generate pair to the level above. Carries flow downward from the top unit into each section, and from each section's unit into its groups. The block also drives its overall propagate and generate, so a wider tree can place it under another lookahead unit.

Top module: `cla_adder64`

## Requirements
- R1: `sum_o` equals the low 64 bits of `a_i + b_i + c_i`, where the operands are unsigned.
- R2: `c_o` equals bit 64 of the 65-bit unsigned sum `a_i + b_i + c_i`.
- R3: `p_o` is 1 exactly when every bit of `a_i ^ b_i` is 1, which means a carry-in would pass through all 64 bits.
- R4: `g_o` is 1 exactly when `a_i + b_i` overflows 64 bits with the carry-in taken as 0.
- R5: `c_o` always equals `g_o | (p_o & c_i)`.
- R6: With all-ones plus one as the input, the carry crosses every group and section boundary. This holds for `a_i` all ones with either `b_i = 1, c_i = 0` or `b_i = 0, c_i = 1`. The result is `sum_o = 0` and `c_o = 1`.
- R7: All ones plus all ones plus `c_i = 1` gives `sum_o` all ones and `c_o = 1`.
- R8: A carry generated at the top bit of any 4-bit group or 16-bit section reaches the next slice. Alternating patterns such as 0x5555... plus 0xAAAA... make every bit propagate. They give `sum_o = 0` and `c_o = 1` when `c_i = 1`, and all ones with `c_o = 0` when `c_i = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum bits |
| c_o | output | 1 | Carry out of bit 63 |
| p_o | output | 1 | Whole-word propagate |
| g_o | output | 1 | Whole-word generate |

## Verification
The bench targets carries that must cross boundaries. Carry-in into an all-ones word must reach the top. Generates sit at bits 3, 15, 31 and 47, the last bit of a group or section. Alternating words make every bit propagate. A unit whose flattened terms skip one product term, or that routes a section carry to the wrong neighbour, gives a sum off by a power of two at that boundary and may drop the carry-out. A swapped propagate/generate pair at the top shows up as a wrong `p_o` or `g_o`, or as a carry-out that breaks the `g_o | p_o & c_i` identity.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GROUP_W = 4;
  localparam int unsigned FANIN   = 4;
  localparam int unsigned SECT_W  = GROUP_W * FANIN;
  localparam int unsigned ADDER_W = SECT_W * FANIN;
  typedef logic [ADDER_W-1:0] word_t;
endpackage

// File: rtl/cla_lcu.sv
// Lookahead carry unit: flat SOP carries plus own propagate/generate.
module cla_lcu #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         c_i,
  output logic [N-1:0] c_o,  // c_o[k]: carry out of input pair k
  output logic         p_o,
  output logic         g_o
);
  // Carry out of position k, expanded to products; no term uses another carry.
  function automatic logic carry_at(input logic [N-1:0] p, input logic [N-1:0] g,
                                    input logic cin, input int k);
    logic r;
    logic t;
    r = 1'b0;
    for (int j = 0; j <= k; j++) begin
      t = g[j];
      for (int m = j + 1; m <= k; m++) t &= p[m];
      r |= t;
    end
    t = cin;
    for (int m = 0; m <= k; m++) t &= p[m];
    r |= t;
    return r;
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_carry
    assign c_o[k] = carry_at(p_i, g_i, c_i, k);
  end

  assign p_o = &p_i;
  assign g_o = carry_at(p_i, g_i, 1'b0, N - 1);
endmodule

// File: rtl/cla_group.sv
// 4-bit group: bit pg, internal lookahead carries, sum, group pg.
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         p_o,
  output logic         g_o
);
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_g;
  logic [W-1:0] carry;
  logic         carry_unused;

  assign bit_p = a_i ^ b_i;
  assign bit_g = a_i & b_i;

  cla_lcu #(.N(W)) u_lcu (
    .p_i(bit_p),
    .g_i(bit_g),
    .c_i(c_i),
    .c_o(carry),
    .p_o(p_o),
    .g_o(g_o)
  );

  // group carry-out is formed one level up
  assign carry_unused = carry[W-1];

  assign sum_o[0] = bit_p[0] ^ c_i;
  for (genvar k = 1; k < W; k++) begin : g_sum
    assign sum_o[k] = bit_p[k] ^ carry[k-1];
  end
endmodule

// File: rtl/cla_section.sv
// 16-bit section: FANIN groups joined by one first-level LCU.
module cla_section #(
  parameter int unsigned GW = 4,
  parameter int unsigned N  = 4
) (
  input  logic [GW*N-1:0] a_i,
  input  logic [GW*N-1:0] b_i,
  input  logic            c_i,
  output logic [GW*N-1:0] sum_o,
  output logic            p_o,
  output logic            g_o
);
  logic [N-1:0] grp_p;
  logic [N-1:0] grp_g;
  logic [N-1:0] grp_cin;
  logic [N-1:0] carry;
  logic         carry_unused;

  assign grp_cin = {carry[N-2:0], c_i};

  for (genvar k = 0; k < N; k++) begin : g_grp
    cla_group #(.W(GW)) u_grp (
      .a_i  (a_i[k*GW +: GW]),
      .b_i  (b_i[k*GW +: GW]),
      .c_i  (grp_cin[k]),
      .sum_o(sum_o[k*GW +: GW]),
      .p_o  (grp_p[k]),
      .g_o  (grp_g[k])
    );
  end

  cla_lcu #(.N(N)) u_lcu (
    .p_i(grp_p),
    .g_i(grp_g),
    .c_i(c_i),
    .c_o(carry),
    .p_o(p_o),
    .g_o(g_o)
  );

  // section carry-out comes from the second-level unit
  assign carry_unused = carry[N-1];
endmodule

// File: rtl/cla_adder64.sv
module cla_adder64
  import cla_pkg::*;
(
  input  logic [ADDER_W-1:0] a_i,
  input  logic [ADDER_W-1:0] b_i,
  input  logic               c_i,
  output logic [ADDER_W-1:0] sum_o,
  output logic               c_o,
  output logic               p_o,
  output logic               g_o
);
  logic [FANIN-1:0] sec_p;
  logic [FANIN-1:0] sec_g;
  logic [FANIN-1:0] sec_cin;
  logic [FANIN-1:0] carry;

  assign sec_cin = {carry[FANIN-2:0], c_i};

  for (genvar k = 0; k < FANIN; k++) begin : g_sec
    cla_section #(.GW(GROUP_W), .N(FANIN)) u_sec (
      .a_i  (a_i[k*SECT_W +: SECT_W]),
      .b_i  (b_i[k*SECT_W +: SECT_W]),
      .c_i  (sec_cin[k]),
      .sum_o(sum_o[k*SECT_W +: SECT_W]),
      .p_o  (sec_p[k]),
      .g_o  (sec_g[k])
    );
  end

  cla_lcu #(.N(FANIN)) u_lcu_top (
    .p_i(sec_p),
    .g_i(sec_g),
    .c_i(c_i),
    .c_o(carry),
    .p_o(p_o),
    .g_o(g_o)
  );

  assign c_o = carry[FANIN-1];
endmodule

// File: rtl/cla_adder64_chk.sv
module cla_adder64_chk
  import cla_pkg::*;
(
  input logic [ADDER_W-1:0] a_i,
  input logic [ADDER_W-1:0] b_i,
  input logic               c_i,
  input logic [ADDER_W-1:0] sum_o,
  input logic               c_o,
  input logic               p_o,
  input logic               g_o
);
  logic [ADDER_W:0] ref_full;
  logic [ADDER_W:0] ref_nocin;

  always_comb begin
    ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{ADDER_W{1'b0}}, c_i};
    ref_nocin = {1'b0, a_i} + {1'b0, b_i};
    assert_sum_R1: assert (sum_o == ref_full[ADDER_W-1:0])
      else $error("R1 sum mismatch");
    assert_cout_R2: assert (c_o == ref_full[ADDER_W])
      else $error("R2 carry-out mismatch");
    assert_prop_R3: assert (p_o == &(a_i ^ b_i))
      else $error("R3 propagate mismatch");
    assert_gen_R4: assert (g_o == ref_nocin[ADDER_W])
      else $error("R4 generate mismatch");
    assert_cout_identity_R5: assert (c_o == (g_o | (p_o & c_i)))
      else $error("R5 carry identity broken");
  end
endmodule

bind cla_adder64 cla_adder64_chk u_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i),
  .sum_o(sum_o), .c_o(c_o), .p_o(p_o), .g_o(g_o)
);

// File: tb/cla_adder64_bench.sv
module cla_adder64_bench;
  localparam int W = 64;
  localparam int NVEC = 9;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  // {a, b, cin}
  localparam logic [2*W:0] VEC [NVEC] = '{
    {64'h0, 64'h0, 1'b0},
    {ONES, 64'h0, 1'b1},                                          // R6
    {ONES, ONES, 1'b1},                                           // R7
    {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1},     // R8
    {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0},     // R8
    {64'h0000_8000_8000_8000, 64'h0000_8000_8000_8000, 1'b0},     // R8 sections
    {64'h000F_000F_000F_000F, 64'h0001_0001_0001_0001, 1'b1},     // R8 groups
    {ONES, 64'h1, 1'b0},                                          // R6
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0}      // R4
  };

  logic         clk;
  logic [W-1:0] a, b, sum;
  logic         cin, cout, p, g;
  int           n_chk, n_fail;

  cla_adder64 u_cla_adder64 (
    .a_i(a), .b_i(b), .c_i(cin),
    .sum_o(sum), .c_o(cout), .p_o(p), .g_o(g)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all();
    logic [W:0] full, nocin;
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    nocin = {1'b0, a} + {1'b0, b};
    chk("R1", sum, full[W-1:0]);
    chk("R2", {63'b0, cout}, {63'b0, full[W]});
    chk("R3", {63'b0, p}, {63'b0, &(a ^ b)});
    chk("R4", {63'b0, g}, {63'b0, nocin[W]});
    chk("R5", {63'b0, cout}, {63'b0, g | (p & cin)});
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    a = '0; b = '0; cin = 1'b0;
    @(posedge clk); #1;
    // idle state with zero inputs
    chk("R1", sum, '0);
    chk("R2", {63'b0, cout}, '0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);
      check_all();
    end

    // directed corners with literal expectations
    apply(ONES, 64'h1, 1'b0);
    chk("R6", sum, '0);
    chk("R6", {63'b0, cout}, 64'h1);
    apply(ONES, 64'h0, 1'b1);
    chk("R6", sum, '0);
    chk("R6", {63'b0, cout}, 64'h1);
    apply(ONES, ONES, 1'b1);
    chk("R7", sum, ONES);
    chk("R7", {63'b0, cout}, 64'h1);
    apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    chk("R8", sum, '0);
    chk("R8", {63'b0, cout}, 64'h1);
    apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
    chk("R8", sum, ONES);
    chk("R8", {63'b0, cout}, 64'h0);
    apply(64'h0000_8000_8000_8000, 64'h0000_8000_8000_8000, 1'b0);
    chk("R8", sum, 64'h0001_0001_0001_0000);
    apply(64'h0000_0000_0000_0008, 64'h0000_0000_0000_0008, 1'b0);
    chk("R8", sum, 64'h10);

    for (int i = 0; i < 300; i++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
      check_all();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule